// File: doc/BRIEF.md
# Tick-Driven Watchdog / Countdown Timer

This block is an 8-bit down-counter that advances on one of several prescaled tick-enable inputs. Software picks the tick source, loads a count and selects one of two behaviours. In countdown mode the counter reaches zero, raises a countdown flag, reloads the programmed value and keeps running. In watchdog mode it reaches zero, raises a watchdog flag and stops there.

Each flag has its own enable, and the enabled flags drive an interrupt output. That output is either a level that stays up while an enabled flag is set, or a pulse one system clock wide at each expiry. The watchdog flag cannot be written. It clears as a side effect of reading the status register. The countdown flag is cleared by writing zero to it.

Access is through a byte-wide register port with four addresses. Reads return their data one cycle after the read strobe.

Top module: `wdt_timer`

## Requirements
- R1: After synchronous reset, every register reads as 0x00 and `irq` is low.
- R2: The source field is bits 2:0 at address 2. Code k, for k below NUM_SRC, selects `tick_src[k]`; code 010 selects input 2, the 1 Hz tick. Codes from NUM_SRC upward select no tick. Ticks on unselected inputs have no effect on the count.
- R3: Writing address 3 loads both the counter and the reload value. Reading address 3 returns the present count, which never exceeds the reload value.
- R4: Mode is bits 2:1 at address 1: 01 is countdown, 10 is watchdog. With mode 00 or 11 the count holds whatever ticks arrive.
- R5: In watchdog mode the tick that takes the count from 1 to 0 sets status bit 7. The counter then stays at 0.
- R6: In countdown mode the tick that takes the count from 1 to 0 sets status bit 6 and reloads the programmed value.
- R7: Status bit 7 is read-only: writes to it have no effect. A read of address 0 returns it and clears it on the following edge.
- R8: If a status read and a new watchdog expiry fall in the same cycle, status bit 7 stays set.
- R9: With bit 7 at address 1 clear, `irq` is high, one cycle after the condition arises, while (status bit 7 AND enable bit 2) OR (status bit 6 AND enable bit 1) holds.
- R10: With bit 7 at address 1 set, `irq` is a single-cycle pulse in the cycle after an expiry whose mode has its enable set. Otherwise `irq` stays low.
- R11: Writing address 0 with bit 6 at zero clears the countdown flag. Writing it at one leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| tick_src | input | NUM_SRC | Prescaled tick enables, one cycle wide each |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt, level or pulsed |

## Verification
Directed runs cover the cases a random run rarely reaches:
- ticks on unselected and out-of-range sources, which separate a correct source decode from one that counts any tick;
- both disabled mode codes, which show whether the mode gate holds the count;
- a reload value of one, which gives back-to-back expiries;
- a status read landing exactly on the expiry edge, which shows whether clear or set takes priority.

Random runs with a fixed seed then mix sparse ticks on all inputs, status reads and reloads in each mode and output style. Against a cycle model these expose off-by-one expiry timing, a missing reload and a pulse that lasts too long.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_CFG  = 2'd1;
  localparam logic [1:0] ADR_SRC  = 2'd2;
  localparam logic [1:0] ADR_CNT  = 2'd3;

  // status register bit positions
  localparam int BIT_WDF  = 7;
  localparam int BIT_CDF  = 6;
  localparam int BIT_WDIE = 2;
  localparam int BIT_CDIE = 1;
  // config register bit positions
  localparam int BIT_PULSE = 7;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_CD  = 2'b01,
    MODE_WD  = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_SRC-1:0] ticks,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  logic [NUM_SRC-1:0] hit;

  // one match term per source; codes past the last source match nothing
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = ticks[i] && (sel == SEL_W'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             run,
  input  logic             autoreload,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rel,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic step;

  assign step   = run && tick && !load && (cnt != ZERO);
  assign expire = step && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ZERO;
      rel <= ZERO;
    end else if (load) begin
      cnt <= load_val;
      rel <= load_val;
    end else if (expire) begin
      cnt <= autoreload ? rel : ZERO;
    end else if (step) begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic mode_wd,
  input  logic mode_cd,
  input  logic stat_rd,
  input  logic cd_clr,
  input  logic wd_ie,
  input  logic cd_ie,
  input  logic pulse,
  output logic wd_flag,
  output logic cd_flag,
  output logic irq
);
  logic wd_n, cd_n, hit_wd, hit_cd, irq_n;

  assign hit_wd = expire && mode_wd;
  assign hit_cd = expire && mode_cd;

  // a new expiry outranks the clear in the same cycle
  always_comb begin
    wd_n = wd_flag;
    if (hit_wd)       wd_n = 1'b1;
    else if (stat_rd) wd_n = 1'b0;
    cd_n = cd_flag;
    if (hit_cd)       cd_n = 1'b1;
    else if (cd_clr)  cd_n = 1'b0;
    if (pulse) irq_n = (hit_wd && wd_ie) || (hit_cd && cd_ie);
    else       irq_n = (wd_n && wd_ie) || (cd_n && cd_ie);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_flag <= 1'b0;
      cd_flag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      wd_flag <= wd_n;
      cd_flag <= cd_n;
      irq     <= irq_n;
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             wd_flag,
  input  logic             cd_flag,
  input  logic [CNT_W-1:0] cnt,
  output logic             wd_ie,
  output logic             cd_ie,
  output logic             pulse,
  output mode_e            mode,
  output logic [SEL_W-1:0] src,
  output logic             cnt_wr,
  output logic             stat_rd,
  output logic             cd_clr,
  output logic [7:0]       rdata
);
  logic [7:0] rd_mux;

  assign cnt_wr  = wr_en && (addr == ADR_CNT);
  assign stat_rd = rd_en && (addr == ADR_STAT);
  assign cd_clr  = wr_en && (addr == ADR_STAT) && !wdata[BIT_CDF];

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_STAT: begin
        rd_mux[BIT_WDF]  = wd_flag;
        rd_mux[BIT_CDF]  = cd_flag;
        rd_mux[BIT_WDIE] = wd_ie;
        rd_mux[BIT_CDIE] = cd_ie;
      end
      ADR_CFG: begin
        rd_mux[BIT_PULSE] = pulse;
        rd_mux[2:1]       = mode;
      end
      ADR_SRC: rd_mux[SEL_W-1:0] = src;
      default: rd_mux = 8'(cnt);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_ie <= 1'b0;
      cd_ie <= 1'b0;
      pulse <= 1'b0;
      mode  <= MODE_OFF;
      src   <= '0;
      rdata <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          ADR_STAT: begin
            wd_ie <= wdata[BIT_WDIE];
            cd_ie <= wdata[BIT_CDIE];
          end
          ADR_CFG: begin
            pulse <= wdata[BIT_PULSE];
            mode  <= mode_e'(wdata[2:1]);
          end
          ADR_SRC: src <= wdata[SEL_W-1:0];
          default: ;
        endcase
      end
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 3,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [7:0]         wdata,
  input  logic [NUM_SRC-1:0] tick_src,
  output logic [7:0]         rdata,
  output logic               irq
);
  logic             wd_ie, cd_ie, pulse, cnt_wr, stat_rd, cd_clr;
  logic             wd_flag, cd_flag, tick, run, expire;
  mode_e            mode;
  logic [SEL_W-1:0] src;
  logic [CNT_W-1:0] cnt_q, rel_q;

  assign run = (mode == MODE_CD) || (mode == MODE_WD);

  wdt_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wd_flag(wd_flag), .cd_flag(cd_flag), .cnt(cnt_q),
    .wd_ie(wd_ie), .cd_ie(cd_ie), .pulse(pulse), .mode(mode), .src(src),
    .cnt_wr(cnt_wr), .stat_rd(stat_rd), .cd_clr(cd_clr), .rdata(rdata)
  );

  wdt_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .ticks(tick_src), .sel(src), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_wr), .load_val(wdata[CNT_W-1:0]),
    .tick(tick), .run(run), .autoreload(mode == MODE_CD),
    .cnt(cnt_q), .rel(rel_q), .expire(expire)
  );

  wdt_flags u_flags (
    .clk(clk), .rst(rst), .expire(expire), .mode_wd(mode == MODE_WD),
    .mode_cd(mode == MODE_CD), .stat_rd(stat_rd), .cd_clr(cd_clr),
    .wd_ie(wd_ie), .cd_ie(cd_ie), .pulse(pulse),
    .wd_flag(wd_flag), .cd_flag(cd_flag), .irq(irq)
  );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rel,
  input logic             run,
  input logic             cnt_wr,
  input logic             expire,
  input logic             mode_wd,
  input logic             wd_flag,
  input logic             pulse,
  input logic             irq
);
  assert_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= rel);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_wd_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_wd && cnt == '0 && !cnt_wr) |=> (cnt == '0));

  assert_ro_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (!wd_flag && !expire) |=> !wd_flag);

  assert_expiry_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (expire && mode_wd) |=> wd_flag);

  assert_pulse_src_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(pulse) && irq) |-> $past(expire));
endmodule

bind wdt_timer wdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .rel(rel_q), .run(run),
  .cnt_wr(cnt_wr), .expire(expire), .mode_wd(mode == wdt_pkg::MODE_WD),
  .wd_flag(wd_flag), .pulse(pulse), .irq(irq)
);

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 4;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [NUM_SRC-1:0] tick_src = 0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0, errors = 0;

  // reference state
  logic [7:0] m_cnt, m_rel, m_rdata;
  logic m_wd, m_cd, m_wdie, m_cdie, m_pulse, m_irq;
  logic [1:0] m_mode;
  logic [2:0] m_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_timer #(.NUM_SRC(NUM_SRC)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tick_src(tick_src), .rdata(rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte();
    return {m_wd, m_cd, 3'b0, m_wdie, m_cdie, 1'b0};
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_rel = 0; m_rdata = 0; m_wd = 0; m_cd = 0; m_wdie = 0;
    m_cdie = 0; m_pulse = 0; m_irq = 0; m_mode = 0; m_src = 0;
  endtask

  // next state from the requirements, using the inputs present at the edge
  task automatic model_step();
    logic tk, ex, nwd, ncd;
    logic [7:0] ncnt, nrel;
    tk = (m_src < 3'(NUM_SRC)) ? tick_src[m_src] : 1'b0;      // R2
    ex = 0; ncnt = m_cnt; nrel = m_rel;
    if (wr_en && addr == 2'd3) begin ncnt = wdata; nrel = wdata; end // R3
    else if ((m_mode == 2'b01 || m_mode == 2'b10) && tk && m_cnt != 0) begin
      if (m_cnt == 1) begin
        ex = 1;
        ncnt = (m_mode == 2'b01) ? m_rel : 8'd0;             // R5 R6
      end else ncnt = m_cnt - 1;
    end
    nwd = (ex && m_mode == 2'b10) ? 1'b1 : (rd_en && addr == 0) ? 1'b0 : m_wd;
    ncd = (ex && m_mode == 2'b01) ? 1'b1 :
          (wr_en && addr == 0 && !wdata[6]) ? 1'b0 : m_cd;
    if (m_pulse)
      m_irq = ex && ((m_mode == 2'b10 && m_wdie) || (m_mode == 2'b01 && m_cdie));
    else
      m_irq = (nwd && m_wdie) || (ncd && m_cdie);
    if (rd_en)
      case (addr)
        2'd0: m_rdata = stat_byte();
        2'd1: m_rdata = {m_pulse, 4'b0, m_mode, 1'b0};
        2'd2: m_rdata = {5'b0, m_src};
        default: m_rdata = m_cnt;
      endcase
    if (wr_en)
      case (addr)
        2'd0: begin m_wdie = wdata[2]; m_cdie = wdata[1]; end
        2'd1: begin m_pulse = wdata[7]; m_mode = wdata[2:1]; end
        2'd2: m_src = wdata[2:0];
        default: ;
      endcase
    m_cnt = ncnt; m_rel = nrel; m_wd = nwd; m_cd = ncd;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " irq"}, {7'b0, irq}, {7'b0, m_irq});
    chk({tag, " rdata"}, rdata, m_rdata);
    wr_en = 0; rd_en = 0; tick_src = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, string tag);
    wr_en = 1; addr = a; wdata = d; cyc(tag);
  endtask

  task automatic rd(logic [1:0] a, string tag);
    rd_en = 1; addr = a; cyc(tag);
  endtask

  task automatic ticks(int n, int idx, string tag);
    for (int i = 0; i < n; i++) begin
      tick_src[idx] = 1'b1; cyc(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), "R1 reset read"); chk("R1 reg value", rdata, 8'h00);
    end

    // load and hold
    wr(3, 8'd5, "R3 load");
    rd(3, "R3 readback"); chk("R3 count", rdata, 8'd5);
    wr(2, 8'b010, "R2 src 1Hz");
    ticks(3, 2, "R4 mode 00 hold");
    wr(1, 8'b0000_0110, "R4 mode 11");
    ticks(3, 2, "R4 mode 11 hold");
    rd(3, "R4 readback"); chk("R4 count held", rdata, 8'd5);

    // source selection
    wr(1, 8'b0000_0010, "R6 mode cd");
    ticks(2, 0, "R2 other source");
    ticks(1, 3, "R2 other source");
    rd(3, "R2 readback"); chk("R2 unselected ignored", rdata, 8'd5);
    ticks(1, 2, "R2 selected");
    rd(3, "R2 readback"); chk("R2 1Hz decrements", rdata, 8'd4);
    wr(2, 8'b101, "R2 src out of range");
    for (int i = 0; i < 4; i++) ticks(1, i, "R2 no source");
    rd(3, "R2 readback"); chk("R2 no tick for code 5", rdata, 8'd4);
    wr(2, 8'b000, "R2 src 0");

    // countdown with reload
    wr(3, 8'd3, "R6 load");
    ticks(3, 0, "R6 count down");
    rd(0, "R6 status"); chk("R6 cd flag", rdata, 8'h40);
    rd(3, "R6 reload"); chk("R6 reloaded", rdata, 8'd3);
    wr(0, 8'h40, "R11 write one keeps");
    rd(0, "R11 status"); chk("R11 flag kept", rdata, 8'h40);
    wr(0, 8'h00, "R11 write zero clears");
    rd(0, "R11 status"); chk("R11 flag cleared", rdata, 8'h00);
    // reload of one: expiry on every tick, pulsed interrupt each time
    wr(0, 8'h02, "R10 cd enable");
    wr(1, 8'h82, "R10 pulse cd");
    wr(3, 8'd1, "R10 load one");
    ticks(2, 0, "R10 back to back");
    cyc("R10 pulse ends");
    chk("R10 single pulse", {7'b0, irq}, 8'h00);

    // watchdog
    wr(0, 8'h00, "R11 clear");
    wr(1, 8'h04, "R5 mode wd level");
    wr(3, 8'd2, "R5 load");
    ticks(3, 0, "R5 count");
    rd(3, "R5 stop"); chk("R5 count stays 0", rdata, 8'd0);
    wr(0, 8'h80, "R7 write bit7");
    wr(0, 8'h84, "R9 enable wd irq");
    cyc("R9 level");
    chk("R9 level irq high", {7'b0, irq}, 8'h01);
    rd(0, "R7 read"); chk("R7 flag seen", rdata, 8'h84);
    rd(0, "R7 read again"); chk("R7 flag cleared", rdata, 8'h04);
    chk("R9 irq drops", {7'b0, irq}, 8'h00);

    // read colliding with expiry
    wr(3, 8'd1, "R8 load");
    rd_en = 1; addr = 0; tick_src[0] = 1; cyc("R8 collide");
    rd(0, "R8 read"); chk("R8 flag kept", rdata, 8'h84);

    // pulsed watchdog
    wr(1, 8'h84, "R10 pulse wd");
    wr(3, 8'd2, "R10 load");
    ticks(2, 0, "R10 expiry");
    chk("R10 pulse high", {7'b0, irq}, 8'h01);
    cyc("R10 after");
    chk("R10 pulse low", {7'b0, irq}, 8'h00);

    // constrained random against the model
    void'($urandom(32'd1234));
    for (int ph = 0; ph < 4; ph++) begin
      wr(0, {1'b0, 1'b0, 3'b0, 2'(ph + 1), 1'b0}, "R9 R10 rand ie");
      wr(1, {ph[0], 4'b0, ph[1] ? 2'b10 : 2'b01, 1'b0}, "R5 R6 rand mode");
      wr(2, 8'($urandom_range(0, 4)), "R2 rand src");
      for (int i = 0; i < 600; i++) begin
        int r;
        r = $urandom_range(0, 99);
        tick_src = 4'($urandom_range(0, 15));
        if (r < 8) begin rd_en = 1; addr = 2'($urandom_range(0, 3)); end
        else if (r < 10) begin wr_en = 1; addr = 3; wdata = 8'($urandom_range(0, 9)); end
        cyc("R6 R7 R8 rand");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule